// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog for a small controller. Software reaches it through a one-cycle write strobe that selects one of two registers. The first is a key register. The second is a period register that holds a 3-bit timeout code and a clock-mode bit. The watchdog stays idle after reset. The ordered byte pair 8'h1E then 8'hE1, written to the key register, starts it. Once it runs, the same pair clears its count. No software write can stop it.

The counter advances on a watchdog tick. The tick runs at half the oscillator rate, or at the full rate when the device is in double-speed mode and the clock-mode bit is 0. If the count reaches its limit before software services it, the block drives a reset pulse of fixed length. It then falls back to the disabled state.

A power-mode input selects normal, idle or power-down operation. The count keeps running in idle. In power-down it holds its value, and it resumes from that value when the mode returns to normal.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is disabled with count zero and `wdt_rst` low, and it produces no pulse until it is enabled.
- R2: A write of 8'hE1 to the key register (`wr_sel`=0), when the write just before it was 8'h1E to the key register, enables the watchdog if it is stopped. It clears the count and the tick phase whether or not the watchdog was already running.
- R3: While the watchdog runs, no write to either register stops it; other key values and period writes leave it counting.
- R4: The overflow occurs on the 6·2^BASE_LOG2·2^WTO-th tick after the last accepted key, where WTO is period bits [2:0]. `wdt_rst` rises at the clock edge of that tick. With halved ticks, that edge is 2·limit oscillator edges after the key edge. With full-rate ticks, it is limit edges after the key edge.
- R5: `wdt_rst` stays high for exactly PULSE_LEN (96) oscillator cycles. After an overflow the watchdog is disabled with count zero.
- R6: The key is accepted only when 8'hE1 is the write that comes straight after 8'h1E. A lone 8'hE1 does nothing. A 1E/E1 pair with any other write between them, in either register, also does nothing.
- R7: The tick is halved unless `speed_x2`=1 and period bit 3 (the clock-mode bit) is 0. In that one case the tick runs at the full oscillator rate.
- R8: The period code is captured when a key is accepted. A period write during a count does not change the current timeout; the new code applies from the next accepted key.
- R9: Idle mode (`pwr_mode`=2'b01) has no effect on counting or on the expiry time.
- R10: In power-down (`pwr_mode`=2'b10 or 2'b11) the count and tick phase hold. Counting resumes from the held value when the mode returns to normal, so each power-down cycle delays the expiry by one oscillator cycle.
- R11: A reset that arrives during power-down leaves the watchdog cleared and disabled, so no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 1 | 0 = key register, 1 = period register |
| wr_data | input | 8 | Write data; period uses [2:0] timeout code and [3] clock-mode bit |
| speed_x2 | input | 1 | Device runs in double-speed mode |
| pwr_mode | input | 2 | 00 normal, 01 idle, 1x power-down |
| wdt_rst | output | 1 | Reset pulse, high for PULSE_LEN cycles after an overflow |

## Verification
The bench runs the timeout with the smallest code and checks each rising and falling edge of the pulse to the exact cycle against the edge of the last accepted key. Several key patterns are tried: a lone E1, a pair split by a period write, and a pair split by another key value must stay silent, while 1E,1E,E1 must count. A service part-way through a count must move the expiry. A period write part-way through a count must shift only the count after it. The three tick-rate combinations are told apart by a limit of 48 versus 96 edges. A power-down stretch of known length must delay the expiry by exactly its length, while idle must not delay it at all.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam logic [7:0] KEY_FIRST  = 8'h1E;
   localparam logic [7:0] KEY_SECOND = 8'hE1;
   localparam logic       SEL_KEY    = 1'b0;
   localparam logic       SEL_PERIOD = 1'b1;

   typedef enum logic [1:0] {
      PM_NORMAL = 2'b00,
      PM_IDLE   = 2'b01,
      PM_DOWN   = 2'b10,
      PM_DOWN2  = 2'b11
   } pmode_t;

   typedef struct packed {
      logic       keep_half;
      logic [2:0] wto;
   } period_t;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
   import kwdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   output logic       key_ok
);
   logic armed_q;
   logic is_key;

   assign is_key = wr_en && (wr_sel == SEL_KEY);
   assign key_ok = is_key && armed_q && (wr_data == KEY_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (wr_en) armed_q <= is_key && (wr_data == KEY_FIRST);
   end
endmodule

// File: rtl/kwdt_tick.sv
module kwdt_tick #(
   parameter bit FAST_OK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic halve,
   output logic tick
);
   logic phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= 1'b0;
      else if (restart) phase_q <= 1'b0;
      else if (run)     phase_q <= ~phase_q;
   end

   generate
      if (FAST_OK) begin : g_sel
         assign tick = run && (!halve || phase_q);
      end else begin : g_half
         logic unused_halve;
         assign unused_halve = halve;
         assign tick = run && phase_q;
      end
   endgenerate
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
   parameter int BASE_LOG2 = 14,
   localparam int CW = BASE_LOG2 + 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          key_ok,
   input  logic [2:0]    wto_in,
   input  logic          tick,
   output logic          en,
   output logic [CW-1:0] cnt,
   output logic          ovf
);
   logic [2:0]    wto_act;
   logic [CW-1:0] lim_m1;

   assign lim_m1 = (CW'(6) << (BASE_LOG2 + int'(wto_act))) - CW'(1);
   assign ovf    = tick && en && (cnt == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         cnt     <= '0;
         wto_act <= '0;
      end else if (key_ok) begin
         en      <= 1'b1;
         cnt     <= '0;
         wto_act <= wto_in;
      end else if (ovf) begin
         en  <= 1'b0;
         cnt <= '0;
      end else if (tick && en) begin
         cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
   parameter int PULSE_LEN = 96,
   localparam int PW = $clog2(PULSE_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active
);
   logic [PW-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         pc_q   <= '0;
      end else if (fire) begin
         active <= 1'b1;
         pc_q   <= '0;
      end else if (active) begin
         if (pc_q == PW'(PULSE_LEN - 1)) active <= 1'b0;
         else                            pc_q   <= pc_q + PW'(1);
      end
   end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int BASE_LOG2 = 14,
   parameter int PULSE_LEN = 96,
   parameter bit FAST_OK   = 1'b1,
   localparam int CW = BASE_LOG2 + 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       speed_x2,
   input  logic [1:0] pwr_mode,
   output logic       wdt_rst
);
   generate
      if (BASE_LOG2 < 1 || BASE_LOG2 > 24) begin : g_bad_base
         $error("kwdt_top: BASE_LOG2 out of range");
      end
      if (PULSE_LEN < 2 || PULSE_LEN > 4096) begin : g_bad_pulse
         $error("kwdt_top: PULSE_LEN out of range");
      end
   endgenerate

   period_t       per_q;
   logic          key_ok, tick, halve, run, en_w, ovf_w;
   logic [CW-1:0] cnt_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              per_q <= '0;
      else if (wr_en && wr_sel == SEL_PERIOD)  per_q <= period_t'(wr_data[3:0]);
   end

   assign halve = !(speed_x2 && !per_q.keep_half);
   assign run   = en_w && !pwr_mode[1];

   kwdt_keyseq u_key (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .key_ok(key_ok)
   );

   kwdt_tick #(.FAST_OK(FAST_OK)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(key_ok),
      .halve(halve), .tick(tick)
   );

   kwdt_count #(.BASE_LOG2(BASE_LOG2)) u_cnt (
      .clk(clk), .rst_n(rst_n), .key_ok(key_ok), .wto_in(per_q.wto),
      .tick(tick), .en(en_w), .cnt(cnt_w), .ovf(ovf_w)
   );

   kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(ovf_w), .active(wdt_rst)
   );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int CW = 24,
   parameter int PULSE_LEN = 96
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          wr_sel,
   input logic [7:0]    wr_data,
   input logic [1:0]    pwr_mode,
   input logic          en,
   input logic [CW-1:0] cnt,
   input logic          ovf,
   input logic          tick,
   input logic          halve,
   input logic          wdt_rst
);
   logic [12:0] wlen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wlen <= '0;
      else if (wdt_rst) wlen <= wlen + 13'd1;
      else              wlen <= '0;
   end

   AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wdt_rst) |=> !wdt_rst); // R1
   AST_KEY_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> $past(wr_en && wr_sel == 1'b0 && wr_data == 8'hE1)); // R2
   AST_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ovf) |=> en); // R3
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst) |-> (wlen == 13'(PULSE_LEN))); // R5
   AST_HALF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && halve && $stable(halve)) |=> !tick); // R7
   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode[1] && !wr_en) |=> $stable(cnt)); // R10
endmodule

bind kwdt_top kwdt_chk #(.CW(CW), .PULSE_LEN(PULSE_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .pwr_mode(pwr_mode), .en(en_w), .cnt(cnt_w),
   .ovf(ovf_w), .tick(tick), .halve(halve), .wdt_rst(wdt_rst)
);

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;
   localparam int BASE = 3;
   localparam int PLEN = 96;
   localparam int LIM0 = 6 << BASE;   // 48 ticks for WTO=0

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       speed_x2 = 1'b0;
   logic [1:0] pwr_mode = 2'b00;
   logic       wdt_rst;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   logic prev_rst = 1'b0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      logic  val;
      string req;
   } ev_t;
   ev_t q[$];

   kwdt_top #(.BASE_LOG2(BASE), .PULSE_LEN(PLEN), .FAST_OK(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .speed_x2(speed_x2), .pwr_mode(pwr_mode),
      .wdt_rst(wdt_rst)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: every edge of wdt_rst must match the head of the queue
   always @(negedge clk) begin
      if (wdt_rst !== prev_rst) begin
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL unexpected edge: wdt_rst=%0b at cycle %0d, expected no change", wdt_rst, cyc);
         end else begin
            ev_t e;
            e = q.pop_front();
            if (e.at != cyc || e.val !== wdt_rst) begin
               errors++;
               $display("FAIL %s: edge to %0b at cycle %0d, expected %0b at cycle %0d",
                        e.req, wdt_rst, cyc, e.val, e.at);
            end
         end
         prev_rst = wdt_rst;
      end
   end

   task automatic wr(input logic sel, input logic [7:0] d, output int edge_at);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      edge_at = cyc;
      wr_en = 1'b0;
   endtask

   task automatic wr_n(input logic sel, input logic [7:0] d);
      int tmp;
      wr(sel, d, tmp);
   endtask

   task automatic expect_pulse(input int rise_at, input string req);
      q.push_back('{at: rise_at, val: 1'b1, req: req});
      q.push_back('{at: rise_at + PLEN, val: 1'b0, req: req});
   endtask

   task automatic settle(input int n, input string req);
      repeat (n) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d expected edges missing, expected 0", req, q.size());
         q.delete();
      end
   endtask

   task automatic enable(output int e);
      wr_n(1'b0, 8'h1E);
      wr(1'b0, 8'hE1, e);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      int e;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (wdt_rst !== 1'b0) begin
         errors++;
         $display("FAIL R1: wdt_rst=%0b after reset, expected 0", wdt_rst);
      end
      settle(300, "R1");

      // R6: malformed key sequences must be ignored
      wr_n(1'b0, 8'hE1);
      settle(250, "R6");
      wr_n(1'b0, 8'h1E); wr_n(1'b1, 8'h00); wr_n(1'b0, 8'hE1);
      settle(250, "R6");
      wr_n(1'b0, 8'h1E); wr_n(1'b0, 8'h55); wr_n(1'b0, 8'hE1);
      settle(250, "R6");

      // R2 R4 R5: halved ticks, WTO=0 -> 2*48 edges; then disabled
      enable(e);
      expect_pulse(e + 2*LIM0, "R4");
      settle(260, "R5");
      settle(300, "R5");

      // R6: 1E,1E,E1 is still a valid key
      wr_n(1'b0, 8'h1E); wr_n(1'b0, 8'h1E); wr(1'b0, 8'hE1, e);
      expect_pulse(e + 2*LIM0, "R6");
      settle(260, "R6");

      // R2 service, R3 writes cannot stop, R8 period capture
      enable(e);
      repeat (40) @(negedge clk);
      enable(e);                          // service: restart from here
      wr_n(1'b1, 8'h01);                  // WTO=1, not yet active
      wr_n(1'b0, 8'h00);
      wr_n(1'b0, 8'h1E);
      wr_n(1'b1, 8'h01);
      expect_pulse(e + 2*LIM0, "R3");
      settle(260, "R8");
      enable(e);                          // now WTO=1 applies
      expect_pulse(e + 4*LIM0, "R8");
      settle(420, "R8");
      wr_n(1'b1, 8'h00);

      // R7: full-rate and held-half tick choices
      speed_x2 = 1'b1;
      enable(e);
      expect_pulse(e + LIM0, "R7");
      settle(200, "R7");
      wr_n(1'b1, 8'h08);
      enable(e);
      expect_pulse(e + 2*LIM0, "R7");
      settle(260, "R7");
      speed_x2 = 1'b0;
      wr_n(1'b1, 8'h00);

      // R9: idle does not slow the count
      pwr_mode = 2'b01;
      enable(e);
      expect_pulse(e + 2*LIM0, "R9");
      settle(260, "R9");
      pwr_mode = 2'b00;

      // R10: 50 cycles of power-down delay expiry by 50
      enable(e);
      expect_pulse(e + 2*LIM0 + 50, "R10");
      repeat (20) @(negedge clk);
      pwr_mode = 2'b10;
      repeat (50) @(negedge clk);
      pwr_mode = 2'b00;
      settle(300, "R10");

      // R11: reset during power-down clears and disables
      enable(e);
      repeat (10) @(negedge clk);
      pwr_mode = 2'b11;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pwr_mode = 2'b00;
      checks++;
      if (wdt_rst !== 1'b0) begin
         errors++;
         $display("FAIL R11: wdt_rst=%0b after reset, expected 0", wdt_rst);
      end
      settle(300, "R11");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule